// File: doc/BRIEF.md
# Bit-Test-and-Skip Execution Unit

This unit executes the two conditional bit-test-and-skip instructions of an 8-bit core that uses 16-bit instruction words and overlaps the fetch of the next instruction with the execution of the current one. It decodes an instruction word and forms a 12-bit data-memory address. The address comes from the access bank, from a bank register, or from an index register plus an offset. The unit then tests one bit of the byte read back and decides whether the instruction already fetched has to be turned into a no-op.

When a skip is taken, the unit tells the fetch stage how many squash cycles follow. There is one for a one-word successor and two for a two-word successor. The unit also reports the instruction's total cycle count. While a squash is in progress, the slot's instruction word is a discarded one and is not executed. No status flags and no registers are written.

Top module: `bts_unit`

## Requirements
- R1: The opcode is instr_i[15:12]. Value 4'b1010 is skip-if-set and 4'b1011 is skip-if-clear. The bit number is instr_i[11:9], the bank flag is instr_i[8] and the file address f is instr_i[7:0]. is_bts_o is high in the same cycle when instr_valid_i carries one of these two opcodes and no squash is in progress.
- R2: A valid word with any other opcode is ignored. is_bts_o and skip_o stay low, cycles_o is 0, and squash_o is low in the following cycle.
- R3: Skip-if-clear drives skip_o high in the same cycle exactly when bit b of rd_data_i is 0.
- R4: Skip-if-set drives skip_o high in the same cycle exactly when bit b of rd_data_i is 1.
- R5: With the bank flag at 0 and indexed mode not in effect, rd_addr_o is {4'h0,f} for f < 0x60 and {4'hF,f} for f >= 0x60.
- R6: With the bank flag at 1, rd_addr_o is {bsr_i,f}, whatever ext_en_i is.
- R7: With the bank flag at 0, ext_en_i high and f <= 0x5F, rd_addr_o is (idx_i + f) mod 4096.
- R8: For an executed test, cycles_o is 1 with no skip, 2 for a skip over a one-word successor and 3 for a skip over a two-word successor (next_two_word_i high). cycles_o is 0 otherwise.
- R9: A skip makes squash_o high for one cycle after the skip cycle, or for two consecutive cycles when next_two_word_i was high. squash_o is low after that.
- R10: A bit-test word presented while squash_o is high is ignored. skip_o and is_bts_o stay low and the squash is not extended.
- R11: While rst_ni is low and after its release, squash_o is low until a skip occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | instr_i holds an instruction in execute |
| instr_i | input | 16 | Instruction word |
| bsr_i | input | 4 | Bank select register |
| idx_i | input | 12 | Index register for indexed offset mode |
| ext_en_i | input | 1 | Extended addressing enable |
| next_two_word_i | input | 1 | Prefetched successor is a two-word instruction |
| rd_addr_o | output | 12 | Data-memory read address |
| rd_data_i | input | 8 | Data-memory read data (same cycle) |
| is_bts_o | output | 1 | Bit-test instruction is executing |
| skip_o | output | 1 | Skip taken this cycle |
| squash_o | output | 1 | Current fetched slot is replaced by a no-op |
| cycles_o | output | 2 | Total cycle count of the executing test |

## Verification
rd_addr_o, is_bts_o, skip_o and cycles_o are combinational. The bench checks them shortly after driving inputs at the falling edge, within the same cycle. squash_o is registered and is due one rising edge after the skip cycle, plus one more for a two-word successor. The bench samples it at the falling edges that follow, and checks one further cycle to confirm that it has dropped.

// File: rtl/bts_pkg.sv
package bts_pkg;
  localparam int INSTR_W = 16;
  localparam int FILE_W  = 8;
  localparam int BIT_W   = 3;

  localparam logic [3:0] OP_SKIP_SET = 4'b1010;
  localparam logic [3:0] OP_SKIP_CLR = 4'b1011;

  typedef struct packed {
    logic              hit;
    logic              sense_set;
    logic [BIT_W-1:0]  bit_sel;
    logic              bank_flag;
    logic [FILE_W-1:0] file_addr;
  } bts_dec_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ONE  = 2'd1,
    SQ_TWO  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/bts_decode.sv
module bts_decode
  import bts_pkg::*;
(
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output bts_dec_t           dec_o
);
  logic [3:0] opc;
  assign opc = instr_i[15:12];

  always_comb begin
    dec_o.hit       = valid_i && ((opc == OP_SKIP_SET) || (opc == OP_SKIP_CLR));
    dec_o.sense_set = (opc == OP_SKIP_SET);
    dec_o.bit_sel   = instr_i[11:9];
    dec_o.bank_flag = instr_i[8];
    dec_o.file_addr = instr_i[7:0];
  end
endmodule

// File: rtl/bts_addr_gen.sv
module bts_addr_gen
  import bts_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LOW_SPLIT = 'h60
) (
  input  logic              bank_flag_i,
  input  logic [FILE_W-1:0] file_i,
  input  logic [ADDR_W-FILE_W-1:0] bsr_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic              ext_en_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - FILE_W;
  localparam logic [FILE_W-1:0] SPLIT = FILE_W'(LOW_SPLIT);

  logic low_half;
  assign low_half = (file_i < SPLIT);

  always_comb begin
    if (bank_flag_i)
      addr_o = {bsr_i, file_i};
    else if (ext_en_i && low_half)
      addr_o = idx_i + {{HI_W{1'b0}}, file_i};
    else if (low_half)
      addr_o = {{HI_W{1'b0}}, file_i};
    else
      addr_o = {{HI_W{1'b1}}, file_i};
  end
endmodule

// File: rtl/bts_squash_ctl.sv
module bts_squash_ctl
  import bts_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic skip_i,
  input  logic two_word_i,
  output logic squash_o
);
  sq_state_e state_q, state_d;

  always_comb begin
    state_d = SQ_IDLE;
    unique case (state_q)
      SQ_IDLE: if (skip_i) state_d = two_word_i ? SQ_TWO : SQ_ONE;
      SQ_TWO:  state_d = SQ_ONE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SQ_IDLE;
    else         state_q <= state_d;
  end

  assign squash_o = (state_q != SQ_IDLE);

  a_r9_squash_max_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_o && $past(squash_o)) |=> !squash_o);
  a_r9_two_word_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_i && two_word_i && !squash_o) |=> (squash_o ##1 squash_o));
endmodule

// File: rtl/bts_unit.sv
module bts_unit
  import bts_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int LOW_SPLIT = 'h60
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     instr_valid_i,
  input  logic [INSTR_W-1:0]       instr_i,
  input  logic [ADDR_W-FILE_W-1:0] bsr_i,
  input  logic [ADDR_W-1:0]        idx_i,
  input  logic                     ext_en_i,
  input  logic                     next_two_word_i,
  output logic [ADDR_W-1:0]        rd_addr_o,
  input  logic [DATA_W-1:0]        rd_data_i,
  output logic                     is_bts_o,
  output logic                     skip_o,
  output logic                     squash_o,
  output logic [1:0]               cycles_o
);
  bts_dec_t dec;
  logic     tested_bit;

  // a squashed slot must not execute
  bts_decode u_dec (
    .valid_i (instr_valid_i && !squash_o),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  bts_addr_gen #(.ADDR_W(ADDR_W), .LOW_SPLIT(LOW_SPLIT)) u_addr (
    .bank_flag_i (dec.bank_flag),
    .file_i      (dec.file_addr),
    .bsr_i       (bsr_i),
    .idx_i       (idx_i),
    .ext_en_i    (ext_en_i),
    .addr_o      (rd_addr_o)
  );

  assign tested_bit = rd_data_i[dec.bit_sel];
  assign is_bts_o   = dec.hit;
  assign skip_o     = dec.hit && (tested_bit == dec.sense_set);

  always_comb begin
    if (!dec.hit)     cycles_o = 2'd0;
    else if (!skip_o) cycles_o = 2'd1;
    else              cycles_o = next_two_word_i ? 2'd3 : 2'd2;
  end

  bts_squash_ctl u_sq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .skip_i     (skip_o),
    .two_word_i (next_two_word_i),
    .squash_o   (squash_o)
  );

  a_r10_no_exec_in_squash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> (!skip_o && !is_bts_o));
  a_r9_skip_starts_squash: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |=> squash_o);
  a_r8_skip_cycles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> (cycles_o >= 2'd2));
  a_r6_banked_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_bts_o && instr_i[8]) |-> (rd_addr_o[ADDR_W-1:FILE_W] == bsr_i));
  a_r2_foreign_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_i[15:13] != 3'b101) |-> (cycles_o == 2'd0));
endmodule

// File: tb/bts_unit_tb_top.sv
module bts_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [15:0] ins = '0;
  logic [3:0]  bsr = 4'hA;
  logic [11:0] idx = 12'hFF0;
  logic        ext = 1'b0;
  logic        tw  = 1'b0;
  logic [11:0] addr;
  logic [7:0]  rdat = '0;
  logic        isb, skp, sq;
  logic [1:0]  cyc;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bts_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(vld), .instr_i(ins),
    .bsr_i(bsr), .idx_i(idx), .ext_en_i(ext), .next_two_word_i(tw),
    .rd_addr_o(addr), .rd_data_i(rdat), .is_bts_o(isb), .skip_o(skp),
    .squash_o(sq), .cycles_o(cyc)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_addr(input logic a, input logic e,
                                            input logic [7:0] f);
    if (a) return {bsr, f};
    if (f <= 8'h5F) return e ? 12'((32'(idx) + 32'(f)) % 4096) : {4'h0, f};
    return {4'hF, f};
  endfunction

  // run one instruction, check its execute cycle and the squash slots
  task automatic run(input logic [3:0] op, input logic [2:0] b, input logic a,
                     input logic [7:0] f, input logic [7:0] d, input logic two,
                     input logic chk_addr);
    logic bt = d[b];
    logic is_t = (op == 4'b1010) || (op == 4'b1011);
    logic sk = is_t && ((op == 4'b1011) ? !bt : bt);
    @(negedge clk);
    vld = 1; ins = {op, b, a, f}; rdat = d; tw = two;
    #1;
    if (chk_addr) chk("R5/R6/R7 addr", addr, exp_addr(a, ext, f));
    chk(is_t ? "R1 is_bts" : "R2 is_bts", isb, is_t);
    chk(op == 4'b1011 ? "R3 skip" : (op == 4'b1010 ? "R4 skip" : "R2 skip"), skp, sk);
    chk("R8 cycles", cyc, !is_t ? 0 : (!sk ? 1 : (two ? 3 : 2)));
    @(negedge clk);
    // keep a skipping bit-test word in the squashed slot (R10)
    ins = {4'b1010, 3'd0, 1'b0, 8'h10}; rdat = 8'hFF; tw = 1;
    #1;
    chk("R9 squash1", sq, sk);
    if (sk) begin
      chk("R10 no skip in squash", skp, 0);
      chk("R10 no is_bts in squash", isb, 0);
      if (two) begin
        @(negedge clk); #1;
        chk("R9 squash2", sq, 1);
        chk("R10 no skip in squash2", skp, 0);
      end
      @(negedge clk); vld = 0; #1;
      chk("R9 squash end", sq, 0);
    end else begin
      vld = 0;
    end
  endtask

  initial begin
    #1;
    chk("R11 reset squash", sq, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1 chk("R11 after release", sq, 0);
    // address sweep, non-skipping (set-test of bit 0 on zero data)
    for (int e = 0; e < 2; e++)
      for (int a = 0; a < 2; a++)
        for (int f = 0; f < 256; f++) begin
          ext = e[0];
          run(4'b1010, 3'd0, a[0], 8'(f), 8'h00, 1'b0, 1'b1);
        end
    ext = 0;
    // semantic sweep: both opcodes, every bit, every data byte
    for (int op = 10; op < 12; op++)
      for (int b = 0; b < 8; b++)
        for (int d = 0; d < 256; d++)
          run(4'(op), 3'(b), 1'b0, 8'h20, 8'(d), d[0] ^ b[0], 1'b0);
    // foreign opcodes
    for (int op = 0; op < 16; op++)
      if (op != 10 && op != 11)
        run(4'(op), 3'd1, 1'b0, 8'h30, 8'hA5, 1'b0, 1'b0);
    // reset during pending squash
    run(4'b1011, 3'd0, 1'b0, 8'h01, 8'h00, 1'b1, 1'b0);
    @(negedge clk); vld = 1; ins = {4'b1011, 3'd0, 1'b0, 8'h01}; rdat = 0; tw = 1;
    @(negedge clk); vld = 0; rst_n = 0; #1;
    chk("R11 reset clears squash", sq, 0);
    @(negedge clk); rst_n = 1; #1;
    chk("R11 idle after reset", sq, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule